// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is a memory-mapped port controller for up to 32 pins. A host reaches it through a plain register bus made of a write strobe, a word address, write data and combinational read data. It holds three per-port registers: output data, direction and a synchronised input view. It also holds a small configuration byte and a four-bit function-select field for each pin. From these it drives the pad controls of every pin: the output value, output enable, input buffer enable, pull enable and pull polarity. It also drives a select that gives the pad to a peripheral function.

The output and direction registers have alias addresses for single-write atomic updates. On the output register these set, clear or invert only the bits written as 1. On the direction register they set or clear those bits. A plain write to the output register replaces every bit, so a partial update through that address needs a read-modify-write by the host. A pin that is not an output and has its pull enabled takes its pull polarity from its own output data bit. When a pin's mux-enable bit is set, the port stops driving that pad and the peripheral chosen by the pin's function field takes over.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0. Every pad control output is 0, so each pin is an input with its buffer, pull and peripheral select off, and its function field selects function A (value 0).
- R2: A write to word 0 (output data) replaces all output bits. Word 0 reads back the output register. When the peripheral select of a pin is 0, pad_out carries that pin's output bit.
- R3: Writing word 1 sets, word 2 clears and word 3 inverts the output bits written as 1. Output bits written as 0 keep their value.
- R4: Word 4 is the direction register. Word 5 sets and word 6 clears the direction bits written as 1, and zero bits have no effect. A 1 makes the pin an output: pad_oe follows the bit unless the pin is handed to a peripheral. A write to any output address leaves the direction register unchanged.
- R5: Reads of words 1 to 3 return the output register, and reads of words 5 and 6 return the direction register.
- R6: Word 7 returns pin levels through a two-flop synchroniser. A level applied before a clock edge is visible after the second edge and not after the first. A pin whose input-enable bit is 0 reads 0, and writes to word 7 are ignored.
- R7: Pin p's configuration byte lies in word 8 + p/4, byte lane p%4. Bit 0 is input enable and drives pad_ie. Bit 1 is pull enable. Bit 2 is mux enable. The other bits read 0.
- R8: pad_pull_en is 1 only when pull enable is set and the direction bit is 0. pad_pull_up then equals the pin's output bit (1 pull-up, 0 pull-down).
- R9: Pin p's four-bit function field lies in word 16 + p/8 at bit 4*(p%8). An even pin therefore uses the low nibble of byte p/2 and an odd pin uses the high nibble. The field drives pad_func[4p+3:4p].
- R10: When mux enable is set, pad_periph_sel is 1 and the port forces pad_oe and pad_out for that pin to 0. The output and direction register contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | NUM_PINS | Raw pin levels |
| pad_out | output | NUM_PINS | Output value from the port |
| pad_oe | output | NUM_PINS | Output enable from the port |
| pad_ie | output | NUM_PINS | Input buffer enable |
| pad_pull_en | output | NUM_PINS | Pull resistor enable |
| pad_pull_up | output | NUM_PINS | Pull polarity, 1 is up |
| pad_periph_sel | output | NUM_PINS | Pad handed to a peripheral |
| pad_func | output | 4*NUM_PINS | Peripheral function per pin |

## Verification
A vector table drives plain, set, clear and toggle writes with overlapping and all-zero masks. Each result is compared with an independently computed register image, which separates a replace from a merge and an active 1 from an ignored 0. Directed steps then move one pin through the pull, output and peripheral states. These steps tell the pull polarity apart from the direction gating and the peripheral release. Other steps put distinct nibbles on an even and an odd pin to expose swapped lane placement. The input path is read one and two edges after a change, which separates the right synchroniser depth from one flop too few.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int REG_W      = 32;
  localparam int FUNC_W     = 4;
  localparam int CFG_LANES  = 4;
  localparam int FUNC_LANES = 8;

  // word addresses
  localparam int A_OUT  = 0;
  localparam int A_OSET = 1;
  localparam int A_OCLR = 2;
  localparam int A_OTGL = 3;
  localparam int A_DIR  = 4;
  localparam int A_DSET = 5;
  localparam int A_DCLR = 6;
  localparam int A_IN   = 7;
  localparam int A_CFG  = 8;
  localparam int A_MUX  = 16;

  // configuration byte bit positions
  localparam int CB_IE = 0;
  localparam int CB_PE = 1;
  localparam int CB_ME = 2;

  typedef enum logic [1:0] {UPD_LOAD, UPD_SET, UPD_CLR, UPD_TGL} upd_e;

  function automatic logic [REG_W-1:0] apply_upd(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] wd,
                                                 input upd_e op);
    case (op)
      UPD_SET: return cur | wd;
      UPD_CLR: return cur & ~wd;
      UPD_TGL: return cur ^ wd;
      default: return wd;
    endcase
  endfunction

  function automatic int cfg_word(input int pin);  return A_CFG + pin / CFG_LANES;    endfunction
  function automatic int cfg_lsb(input int pin);   return (pin % CFG_LANES) * 8;      endfunction
  function automatic int func_word(input int pin); return A_MUX + pin / FUNC_LANES;   endfunction
  function automatic int func_lsb(input int pin);  return (pin % FUNC_LANES) * FUNC_W; endfunction
endpackage

// File: rtl/gpio_port_outdir.sv
module gpio_port_outdir
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] dir_q
);
  logic wr_out_any, wr_set, wr_tgl, wr_dir_any;
  upd_e out_op, dir_op;
  logic [REG_W-1:0] out_full, dir_full;

  always_comb begin
    wr_out_any = 1'b0;
    wr_dir_any = 1'b0;
    out_op     = UPD_LOAD;
    dir_op     = UPD_LOAD;
    if (we) begin
      case (addr)
        ADDR_W'(A_OUT):  begin wr_out_any = 1'b1; out_op = UPD_LOAD; end
        ADDR_W'(A_OSET): begin wr_out_any = 1'b1; out_op = UPD_SET;  end
        ADDR_W'(A_OCLR): begin wr_out_any = 1'b1; out_op = UPD_CLR;  end
        ADDR_W'(A_OTGL): begin wr_out_any = 1'b1; out_op = UPD_TGL;  end
        ADDR_W'(A_DIR):  begin wr_dir_any = 1'b1; dir_op = UPD_LOAD; end
        ADDR_W'(A_DSET): begin wr_dir_any = 1'b1; dir_op = UPD_SET;  end
        ADDR_W'(A_DCLR): begin wr_dir_any = 1'b1; dir_op = UPD_CLR;  end
        default: ;
      endcase
    end
  end

  assign wr_set   = wr_out_any && (out_op == UPD_SET);
  assign wr_tgl   = wr_out_any && (out_op == UPD_TGL);
  assign out_full = apply_upd(REG_W'(out_q), wdata, out_op);
  assign dir_full = apply_upd(REG_W'(dir_q), wdata, dir_op);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_out_any) out_q <= out_full[NUM_PINS-1:0];
      if (wr_dir_any) dir_q <= dir_full[NUM_PINS-1:0];
    end
  end

  // R3
  out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> out_q == ($past(out_q) | $past(wdata[NUM_PINS-1:0])));
  // R3
  out_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tgl |=> out_q == ($past(out_q) ^ $past(wdata[NUM_PINS-1:0])));
  // R4
  dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_any |=> $stable(dir_q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] sync_q
);
  logic [NUM_PINS-1:0] meta_q;
  logic [1:0]          warm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      warm_q <= {warm_q[0], 1'b1};
    end
  end

  // R6
  in_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q[1] |-> sync_q == $past(pin_in, 2));
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [REG_W-1:0]           wdata,
  output logic [NUM_PINS-1:0]        ie,
  output logic [NUM_PINS-1:0]        pe,
  output logic [NUM_PINS-1:0]        me,
  output logic [NUM_PINS*FUNC_W-1:0] func,
  output logic [REG_W-1:0]           rdata
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int CW = cfg_word(p);
    localparam int CL = cfg_lsb(p);
    localparam int FW = func_word(p);
    localparam int FL = func_lsb(p);
    logic cfg_wr, func_wr;
    assign cfg_wr  = we && (addr == ADDR_W'(CW));
    assign func_wr = we && (addr == ADDR_W'(FW));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ie[p] <= 1'b0;
        pe[p] <= 1'b0;
        me[p] <= 1'b0;
        func[p*FUNC_W +: FUNC_W] <= '0;
      end else begin
        if (cfg_wr) begin
          ie[p] <= wdata[CL + CB_IE];
          pe[p] <= wdata[CL + CB_PE];
          me[p] <= wdata[CL + CB_ME];
        end
        if (func_wr) func[p*FUNC_W +: FUNC_W] <= wdata[FL +: FUNC_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr == ADDR_W'(cfg_word(p))) begin
        rdata[cfg_lsb(p) + CB_IE] = ie[p];
        rdata[cfg_lsb(p) + CB_PE] = pe[p];
        rdata[cfg_lsb(p) + CB_ME] = me[p];
      end
      if (addr == ADDR_W'(func_word(p)))
        rdata[func_lsb(p) +: FUNC_W] = func[p*FUNC_W +: FUNC_W];
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_PINS-1:0]        pin_in,
  output logic [NUM_PINS-1:0]        pad_out,
  output logic [NUM_PINS-1:0]        pad_oe,
  output logic [NUM_PINS-1:0]        pad_ie,
  output logic [NUM_PINS-1:0]        pad_pull_en,
  output logic [NUM_PINS-1:0]        pad_pull_up,
  output logic [NUM_PINS-1:0]        pad_periph_sel,
  output logic [NUM_PINS*FUNC_W-1:0] pad_func
);
  logic [NUM_PINS-1:0] out_q, dir_q, sync_q, ie, pe, me, in_view;
  logic [REG_W-1:0]    cfg_rdata;

  gpio_port_outdir #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_outdir (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .out_q(out_q), .dir_q(dir_q)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sync_q(sync_q)
  );

  gpio_pin_cfg #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .ie(ie), .pe(pe), .me(me), .func(pad_func), .rdata(cfg_rdata)
  );

  assign in_view        = sync_q & ie;
  assign pad_ie         = ie;
  assign pad_periph_sel = me;
  assign pad_oe         = dir_q & ~me;
  assign pad_out        = out_q & ~me;
  assign pad_pull_en    = pe & ~dir_q;
  assign pad_pull_up    = pad_pull_en & out_q;

  always_comb begin
    case (bus_addr)
      ADDR_W'(A_OUT), ADDR_W'(A_OSET), ADDR_W'(A_OCLR), ADDR_W'(A_OTGL):
        bus_rdata = REG_W'(out_q);
      ADDR_W'(A_DIR), ADDR_W'(A_DSET), ADDR_W'(A_DCLR):
        bus_rdata = REG_W'(dir_q);
      ADDR_W'(A_IN):
        bus_rdata = REG_W'(in_view);
      default:
        bus_rdata = cfg_rdata;
    endcase
  end

  // R10
  periph_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_periph_sel & (pad_oe | pad_out)) == '0);
  // R8
  pull_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_en & dir_q) == '0);
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int N = 32;
  localparam int AW = 5;

  typedef struct packed {
    logic [4:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp_out;
    logic [31:0] exp_dir;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{5'd0, 32'h0000_00F0, 32'h0000_00F0, 32'h0000_0000},
    '{5'd1, 32'h0000_0F0F, 32'h0000_0FFF, 32'h0000_0000},
    '{5'd2, 32'h0000_00FF, 32'h0000_0F00, 32'h0000_0000},
    '{5'd3, 32'hFF00_0F00, 32'hFF00_0000, 32'h0000_0000},
    '{5'd1, 32'h0000_0000, 32'hFF00_0000, 32'h0000_0000},
    '{5'd4, 32'h0000_FFFF, 32'hFF00_0000, 32'h0000_FFFF},
    '{5'd5, 32'h00FF_0000, 32'hFF00_0000, 32'h00FF_FFFF},
    '{5'd6, 32'h0000_00F0, 32'hFF00_0000, 32'h00FF_FF0F},
    '{5'd3, 32'h8000_0001, 32'h7F00_0001, 32'h00FF_FF0F},
    '{5'd2, 32'h0000_0000, 32'h7F00_0001, 32'h00FF_FF0F},
    '{5'd6, 32'h0000_0000, 32'h7F00_0001, 32'h00FF_FF0F},
    '{5'd0, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 32'h00FF_FF0F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pad_out, pad_oe, pad_ie, pad_pull_en, pad_pull_up, pad_periph_sel;
  logic [N*4-1:0] pad_func;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_port #(.NUM_PINS(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
    .pad_periph_sel(pad_periph_sel), .pad_func(pad_func)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic check_reset_state(input string tag);
    logic [31:0] d;
    rd(0, d);  chk({tag, " R1 out"}, d, 32'h0);
    rd(4, d);  chk({tag, " R1 dir"}, d, 32'h0);
    rd(7, d);  chk({tag, " R1 in"}, d, 32'h0);
    rd(8, d);  chk({tag, " R1 cfg"}, d, 32'h0);
    rd(16, d); chk({tag, " R1 mux"}, d, 32'h0);
    chk({tag, " R1 pads"}, pad_out | pad_oe | pad_ie | pad_pull_en | pad_pull_up | pad_periph_sel, 32'h0);
    chk({tag, " R1 func"}, pad_func[31:0] | pad_func[127:96], 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state("init");

    // R2 R3 R4 vector walk
    for (int i = 0; i < 12; i++) begin
      wr(int'(VEC[i].addr), VEC[i].wd);
      rd(0, d); chk($sformatf("R2/R3 out vec %0d", i), d, VEC[i].exp_out);
      rd(4, d); chk($sformatf("R4 dir vec %0d", i), d, VEC[i].exp_dir);
    end

    // R5 alias reads
    rd(1, d); chk("R5 oset read", d, 32'hA5A5_5A5A);
    rd(2, d); chk("R5 oclr read", d, 32'hA5A5_5A5A);
    rd(3, d); chk("R5 otgl read", d, 32'hA5A5_5A5A);
    rd(5, d); chk("R5 dset read", d, 32'h00FF_FF0F);
    rd(6, d); chk("R5 dclr read", d, 32'h00FF_FF0F);
    chk("R4 pad_oe", pad_oe, 32'h00FF_FF0F);
    chk("R2 pad_out", pad_out, 32'hA5A5_5A5A);

    // R6 input sync and masking
    wr(8, 32'h0101_0101);
    chk("R7 pad_ie", pad_ie, 32'h0000_000F);
    @(negedge clk);
    pin_in = '1; bus_addr = AW'(7);
    @(negedge clk); #1 chk("R6 one edge", bus_rdata, 32'h0);
    @(negedge clk); #1 chk("R6 two edges masked", bus_rdata, 32'h0000_000F);
    wr(7, 32'h0);
    rd(7, d); chk("R6 write ignored", d, 32'h0000_000F);

    // R7 config layout
    wr(9, 32'hFFFF_FFFF);
    rd(9, d); chk("R7 cfg readback", d, 32'h0707_0707);
    wr(9, 32'h0000_0402);
    rd(9, d); chk("R7 cfg lanes", d, 32'h0000_0402);

    // R8 pull polarity and gating
    chk("R8 pull_en pin4", 32'(pad_pull_en[4]), 32'h1);
    chk("R8 pull_up pin4", 32'(pad_pull_up[4]), 32'h1);
    wr(2, 32'h0000_0010);
    chk("R8 pull_en kept", 32'(pad_pull_en[4]), 32'h1);
    chk("R8 pull down", 32'(pad_pull_up[4]), 32'h0);
    wr(5, 32'h0000_0010);
    chk("R8 output no pull", 32'(pad_pull_en[4]), 32'h0);
    wr(6, 32'h0000_0010);

    // R10 peripheral handover
    wr(5, 32'h0000_0020);
    wr(1, 32'h0000_0020);
    chk("R10 periph sel", pad_periph_sel, 32'h0000_0020);
    chk("R10 oe released", 32'(pad_oe[5]), 32'h0);
    chk("R10 out released", 32'(pad_out[5]), 32'h0);
    rd(0, d); chk("R10 out kept", d & 32'h20, 32'h20);
    wr(9, 32'h0000_0002);
    chk("R10 oe back", 32'(pad_oe[5]), 32'h1);
    chk("R10 out back", 32'(pad_out[5]), 32'h1);

    // R9 function nibbles
    wr(16, 32'h0070_0900);
    rd(16, d); chk("R9 mux readback", d, 32'h0070_0900);
    chk("R9 pin5 odd", 32'(pad_func[23:20]), 32'h7);
    chk("R9 pin2 even", 32'(pad_func[11:8]), 32'h9);
    chk("R9 pin3 default A", 32'(pad_func[15:12]), 32'h0);
    wr(19, 32'hF000_0000);
    chk("R9 pin31", 32'(pad_func[127:124]), 32'hF);

    // R8 pull request on an output pin
    wr(8, 32'h0000_0003);
    chk("R8 pin0 output", 32'(pad_pull_en[0]), 32'h0);

    // R1 reset again
    pin_in = '0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_reset_state("rerun");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule